// File: doc/BRIEF.md
# Command-Buffered SPI Transfer Engine

This block is an SPI master that carries out a whole transaction from a shared byte buffer. The host fills the buffer through a small memory-mapped interface: a 16-bit header in the two lowest bytes, then the transmit payload. It then writes an action code to the command register. The engine reads the header to get the operation and the byte count, and drives the serial clock, the data-out line and one active-low chip select. It writes received bytes back into the buffer from the lowest address. At the end it sets a done status bit, which reaches the interrupt line through a mask.

A write-then-read sequence, such as an opcode followed by a status read, runs under a single chip-select assertion. A prepend count in a mode register says how many leading payload bytes go out before the read phase. A command can start at once or wait for an external trigger. A halt ends a running transfer at the next byte boundary.

Top module: `spi_cmd_engine`

## Requirements
- R1: After reset every chip select is high (inactive), the serial clock is low, irq is low, and the status register reads 0.
- R2: For a write-only header (byte 0 = header bits 15:8, operation in bits 15:13 = 2, byte count in bits 9:0), the engine sends count bytes taken from buffer offsets 2 upward. Each byte goes MSB first, the serial clock idles low, and data is sampled on its rising edge.
- R3: For operation 1 (read-write), byte i is sent from offset 2+i and the byte received in the same slot is stored at offset i.
- R4: For operation 3 (read-only), the engine first sends P bytes from offset 2 upward, where P is mode register bits 27:24. It then sends count bytes of 0x00 and stores the bytes received in that phase from offset 0 upward.
- R5: During a command only the line chosen by command bits 14:12 goes low. It stays low without a break from the first byte to the last and then rises.
- R6: When a command completes, status bit 0 is set. irq equals status bit 0 AND mask register bit 0.
- R7: Writing 0xFF001F1F to the status register clears status bit 0 (write-one-to-clear).
- R8: Status bit 16 reads 1 while a command runs. A start command written while busy is ignored.
- R9: Action code 2 arms the engine. The command then starts when ext_trig is high, using the chip select given at arming time.
- R10: Action code 3 ends a running command at the next byte boundary. It raises the chip select and leaves status bit 0 clear.
- R11: Action code 4 disarms a pending trigger start, so a later trigger starts nothing.
- R12: Operation 0 (sleep) lasts count byte times with no chip select and no serial clock, then sets status bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Bus access strobe |
| bus_we | input | 1 | Write when 1, read when 0 |
| bus_addr | input | 10 | Byte address; bit 9 = 1 selects the buffer, otherwise word registers at 0x0 command, 0x4 status, 0x8 mask, 0xC mode |
| bus_wdata | input | 32 | Write data (the buffer uses bits 7:0) |
| bus_rdata | output | 32 | Read data, combinational |
| ext_trig | input | 1 | External start trigger |
| miso | input | 1 | Serial data in |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| cs_n | output | 8 | Active-low chip selects |
| irq | output | 1 | Masked done interrupt |

## Verification
A register write takes effect at the clock edge that accepts it. Status reads are combinational. The chip select falls three cycles after a start write, and each byte then takes 16×HALF_PERIOD cycles plus two cycles of sequencing. Because of this spacing, the bench does not count cycles to find results. It polls the busy bit until it clears, then reads status, irq and buffer bytes, all sampled on the falling clock edge. The serial stream is checked as it happens: a device model scores each byte at its eighth rising serial-clock edge against the expected queue. A halt is issued just after the first byte is scored, before that byte's last falling edge, so exactly one byte is due.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;

    typedef enum logic [2:0] {
        OP_SLEEP = 3'd0,
        OP_RW    = 3'd1,
        OP_WR    = 3'd2,
        OP_RD    = 3'd3
    } op_e;

    typedef enum logic [3:0] {
        ACT_NOP   = 4'd0,
        ACT_GO    = 4'd1,
        ACT_TRIG  = 4'd2,
        ACT_HALT  = 4'd3,
        ACT_FLUSH = 4'd4
    } act_e;

    typedef enum logic [2:0] {
        SQ_IDLE, SQ_HDR_HI, SQ_HDR_LO, SQ_XFER, SQ_WAIT, SQ_FINISH, SQ_ABORT
    } sq_e;

    typedef struct packed {
        logic [2:0] op;
        logic [2:0] rsvd;
        logic [9:0] count;
    } hdr_t;

    localparam int REG_CMD  = 0;
    localparam int REG_STAT = 1;
    localparam int REG_MASK = 2;
    localparam int REG_MODE = 3;

    function automatic logic op_uses_cs(input logic [2:0] op);
        return (op == OP_RW) || (op == OP_WR) || (op == OP_RD);
    endfunction

endpackage

// File: rtl/spi_cmd_buf.sv
module spi_cmd_buf #(
    parameter int DEPTH = 512,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          h_we,
    input  logic [AW-1:0] h_addr,
    input  logic [7:0]    h_wdata,
    output logic [7:0]    h_rdata,
    input  logic [AW-1:0] e_raddr,
    output logic [7:0]    e_rdata,
    input  logic          e_we,
    input  logic [AW-1:0] e_waddr,
    input  logic [7:0]    e_wdata
);
    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (e_we) mem[e_waddr] <= e_wdata;
        if (h_we) mem[h_addr]  <= h_wdata;
    end

    assign h_rdata = mem[h_addr];
    assign e_rdata = mem[e_raddr];
endmodule

// File: rtl/spi_cmd_shift.sv
module spi_cmd_shift #(
    parameter int HALF = 2,
    localparam int DW = (HALF > 1) ? $clog2(HALF) : 1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic [7:0] tx,
    input  logic       miso,
    output logic       sclk,
    output logic       mosi,
    output logic       done,
    output logic [7:0] rx
);
    localparam logic [DW-1:0] LAST = DW'(HALF - 1);

    logic          active;
    logic [7:0]    sh;
    logic [2:0]    bitc;
    logic [DW-1:0] div;

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            sclk   <= 1'b0;
            done   <= 1'b0;
            sh     <= '0;
            rx     <= '0;
            bitc   <= '0;
            div    <= '0;
        end else begin
            done <= 1'b0;
            if (start && !active) begin
                active <= 1'b1;
                sh     <= tx;
                bitc   <= '0;
                div    <= '0;
                sclk   <= 1'b0;
            end else if (active) begin
                if (div == LAST) begin
                    div <= '0;
                    if (!sclk) begin
                        sclk <= 1'b1;
                        rx   <= {rx[6:0], miso};
                    end else begin
                        sclk <= 1'b0;
                        if (bitc == 3'd7) begin
                            active <= 1'b0;
                            done   <= 1'b1;
                        end else begin
                            bitc <= bitc + 3'd1;
                            sh   <= {sh[6:0], 1'b0};
                        end
                    end
                end else begin
                    div <= div + DW'(1);
                end
            end
        end
    end

    assign mosi = sh[7];
endmodule

// File: rtl/spi_cmd_seq.sv
module spi_cmd_seq
    import spi_cmd_pkg::*;
#(
    parameter int AW  = 9,
    parameter int CSW = 3,
    localparam int CW = 11
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           go,
    input  logic [CSW-1:0] go_cs,
    input  logic           halt,
    input  logic [3:0]     prep,
    output logic [AW-1:0]  rd_addr,
    input  logic [7:0]     rd_data,
    output logic           wr_en,
    output logic [AW-1:0]  wr_addr,
    output logic [7:0]     wr_data,
    output logic           sh_start,
    output logic [7:0]     sh_tx,
    input  logic           sh_done,
    input  logic [7:0]     sh_rx,
    output logic           cs_act,
    output logic [CSW-1:0] cs_sel,
    output logic           sleeping,
    output logic           busy,
    output logic           done_set
);
    sq_e           st;
    logic [7:0]    hdr_hi;
    logic [2:0]    op;
    logic [3:0]    pre;
    logic [CW-1:0] idx, total;
    logic          halt_q;
    hdr_t          h;
    logic          in_read, capture;
    logic          unused_rsvd;

    assign h           = hdr_t'({hdr_hi, rd_data});
    assign unused_rsvd = ^h.rsvd;
    assign in_read     = (op == OP_RD) && (idx >= CW'(pre));
    assign capture     = (op == OP_RW) || in_read;

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= SQ_IDLE;
            hdr_hi <= '0;
            op     <= '0;
            pre    <= '0;
            idx    <= '0;
            total  <= '0;
            halt_q <= 1'b0;
            cs_sel <= '0;
        end else begin
            if (halt && st != SQ_IDLE) halt_q <= 1'b1;
            case (st)
                SQ_IDLE: begin
                    halt_q <= 1'b0;
                    if (go) begin
                        cs_sel <= go_cs;
                        pre    <= prep;
                        idx    <= '0;
                        st     <= SQ_HDR_HI;
                    end
                end
                SQ_HDR_HI: begin
                    hdr_hi <= rd_data;
                    st     <= SQ_HDR_LO;
                end
                SQ_HDR_LO: begin
                    op <= h.op;
                    if (h.op == OP_RD) total <= CW'(h.count) + CW'(pre);
                    else begin
                        total <= CW'(h.count);
                        pre   <= '0;
                    end
                    st <= SQ_XFER;
                end
                SQ_XFER: begin
                    if (halt_q || halt)      st <= SQ_ABORT;
                    else if (idx == total)   st <= SQ_FINISH;
                    else                     st <= SQ_WAIT;
                end
                SQ_WAIT: begin
                    if (sh_done) begin
                        idx <= idx + CW'(1);
                        st  <= SQ_XFER;
                    end
                end
                default: st <= SQ_IDLE;
            endcase
        end
    end

    always_comb begin
        case (st)
            SQ_HDR_HI: rd_addr = '0;
            SQ_HDR_LO: rd_addr = AW'(1);
            default:   rd_addr = AW'(idx + CW'(2));
        endcase
    end

    assign sh_start = (st == SQ_XFER) && !(halt_q || halt) && (idx != total);
    assign sh_tx    = in_read ? 8'h00 : rd_data;
    assign wr_en    = (st == SQ_WAIT) && sh_done && capture;
    assign wr_addr  = AW'((op == OP_RW) ? idx : idx - CW'(pre));
    assign wr_data  = sh_rx;
    assign sleeping = !op_uses_cs(op);
    assign cs_act   = (st == SQ_XFER || st == SQ_WAIT) && !sleeping;
    assign busy     = (st != SQ_IDLE);
    assign done_set = (st == SQ_FINISH);
endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine
    import spi_cmd_pkg::*;
#(
    parameter int BUF_BYTES   = 512,
    parameter int NCS         = 8,
    parameter int HALF_PERIOD = 2,
    localparam int AW  = $clog2(BUF_BYTES),
    localparam int CSW = $clog2(NCS)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           bus_en,
    input  logic           bus_we,
    input  logic [AW:0]    bus_addr,
    input  logic [31:0]    bus_wdata,
    output logic [31:0]    bus_rdata,
    input  logic           ext_trig,
    input  logic           miso,
    output logic           sclk,
    output logic           mosi,
    output logic [NCS-1:0] cs_n,
    output logic           irq
);
    logic           buf_sel, reg_sel, cmd_wr;
    logic [AW-3:0]  ridx;
    act_e           act;
    logic [CSW-1:0] cmd_cs, arm_cs, go_cs;
    logic           armed, go, halt, busy, done_st, mask_q, done_set;
    logic [3:0]     prep_q;
    logic [7:0]     h_rdata, e_rdata, wr_data, sh_tx, sh_rx;
    logic [AW-1:0]  rd_addr, wr_addr;
    logic           wr_en, sh_start, sh_done, sh_sclk, cs_act, sleeping;
    logic [CSW-1:0] cs_sel;
    logic           unused_bits;

    assign unused_bits = ^bus_wdata;
    assign buf_sel = bus_en && bus_addr[AW];
    assign reg_sel = bus_en && !bus_addr[AW] && (bus_addr[1:0] == 2'b00);
    assign ridx    = bus_addr[AW-1:2];
    assign cmd_wr  = reg_sel && bus_we && (ridx == (AW-2)'(REG_CMD));
    assign act     = act_e'(bus_wdata[3:0]);
    assign cmd_cs  = bus_wdata[12 +: CSW];
    assign halt    = cmd_wr && (act == ACT_HALT);
    assign go      = !busy && ((cmd_wr && act == ACT_GO) || (armed && ext_trig));
    assign go_cs   = (cmd_wr && act == ACT_GO) ? cmd_cs : arm_cs;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed   <= 1'b0;
            arm_cs  <= '0;
            done_st <= 1'b0;
            mask_q  <= 1'b0;
            prep_q  <= '0;
        end else begin
            if (go) armed <= 1'b0;
            if (cmd_wr) begin
                if (act == ACT_TRIG && !busy) begin
                    armed  <= 1'b1;
                    arm_cs <= cmd_cs;
                end else if (act == ACT_HALT || act == ACT_FLUSH) begin
                    armed <= 1'b0;
                end
            end
            if (done_set)
                done_st <= 1'b1;
            else if (reg_sel && bus_we && ridx == (AW-2)'(REG_STAT) && bus_wdata[0])
                done_st <= 1'b0;
            if (reg_sel && bus_we && ridx == (AW-2)'(REG_MASK)) mask_q <= bus_wdata[0];
            if (reg_sel && bus_we && ridx == (AW-2)'(REG_MODE)) prep_q <= bus_wdata[27:24];
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (buf_sel) bus_rdata = {24'd0, h_rdata};
        else if (reg_sel) begin
            case (ridx)
                (AW-2)'(REG_STAT): bus_rdata = {15'd0, busy, 15'd0, done_st};
                (AW-2)'(REG_MASK): bus_rdata = {31'd0, mask_q};
                (AW-2)'(REG_MODE): bus_rdata = {4'd0, prep_q, 24'd0};
                default:           bus_rdata = '0;
            endcase
        end
    end

    spi_cmd_buf #(.DEPTH(BUF_BYTES)) u_buf (
        .clk(clk), .h_we(buf_sel && bus_we), .h_addr(bus_addr[AW-1:0]),
        .h_wdata(bus_wdata[7:0]), .h_rdata(h_rdata),
        .e_raddr(rd_addr), .e_rdata(e_rdata),
        .e_we(wr_en), .e_waddr(wr_addr), .e_wdata(wr_data)
    );

    spi_cmd_seq #(.AW(AW), .CSW(CSW)) u_seq (
        .clk(clk), .rst(rst), .go(go), .go_cs(go_cs), .halt(halt), .prep(prep_q),
        .rd_addr(rd_addr), .rd_data(e_rdata), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .sh_start(sh_start), .sh_tx(sh_tx), .sh_done(sh_done),
        .sh_rx(sh_rx), .cs_act(cs_act), .cs_sel(cs_sel), .sleeping(sleeping),
        .busy(busy), .done_set(done_set)
    );

    spi_cmd_shift #(.HALF(HALF_PERIOD)) u_shift (
        .clk(clk), .rst(rst), .start(sh_start), .tx(sh_tx), .miso(miso),
        .sclk(sh_sclk), .mosi(mosi), .done(sh_done), .rx(sh_rx)
    );

    assign sclk = sh_sclk && !sleeping;
    assign irq  = done_st && mask_q;

    for (genvar g = 0; g < NCS; g++) begin : g_cs
        assign cs_n[g] = !(cs_act && (cs_sel == CSW'(g)));
    end
endmodule

// File: rtl/spi_cmd_chk.sv
module spi_cmd_chk #(
    parameter int NCS = 8
) (
    input logic           clk,
    input logic           rst,
    input logic [NCS-1:0] cs_n,
    input logic           sclk,
    input logic           busy,
    input logic           done_st,
    input logic           irq
);
    p_cs_onehot_r5: assert property (@(posedge clk) disable iff (rst) $onehot0(~cs_n));
    p_sclk_under_cs_r2: assert property (@(posedge clk) disable iff (rst) sclk |-> !(&cs_n));
    p_idle_cs_high_r8: assert property (@(posedge clk) disable iff (rst) !busy |-> (&cs_n));
    p_done_after_busy_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(done_st) |-> $past(busy));
    p_irq_needs_done_r6: assert property (@(posedge clk) disable iff (rst) irq |-> done_st);
endmodule

bind spi_cmd_engine spi_cmd_chk #(.NCS(NCS)) i_chk (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk),
    .busy(busy), .done_st(done_st), .irq(irq)
);

// File: tb/test_spi_cmd_engine.sv
module test_spi_cmd_engine;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_en = 1'b0, bus_we = 1'b0;
    logic [9:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        ext_trig = 1'b0;
    logic        miso, sclk, mosi, irq;
    logic [7:0]  cs_n;

    int checks = 0, fails = 0;
    int sl_bit = 0, sl_k = 0, nbytes = 0, cs_falls = 0, sclk_rises = 0;
    logic [7:0] sl_sh = '0, low_seen = '0, sl_pat;
    logic [7:0] exp_q[$];
    string cur_req = "R2";

    always #5 clk = ~clk;

    spi_cmd_engine i_spi_cmd_engine (
        .clk(clk), .rst(rst), .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_trig(ext_trig),
        .miso(miso), .sclk(sclk), .mosi(mosi), .cs_n(cs_n), .irq(irq)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    // device model: returns 0xA0+k for byte k, scores MOSI bytes against the queue
    assign sl_pat = 8'hA0 + 8'(sl_k);
    assign miso   = sl_pat[3'd7 - 3'(sl_bit)];

    always @(posedge sclk) begin
        sclk_rises++;
        sl_sh = {sl_sh[6:0], mosi};
        if (sl_bit == 7) begin
            sl_bit = 0;
            sl_k++;
            nbytes++;
            if (exp_q.size() == 0) chk(1'b0, cur_req, "unexpected mosi byte", int'(sl_sh), 0);
            else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                chk(sl_sh == e, cur_req, "mosi byte", int'(sl_sh), int'(e));
            end
        end else sl_bit++;
    end

    wire cs_any = ~&cs_n;
    always @(posedge cs_any) begin
        cs_falls++;
        low_seen = ~cs_n;
    end

    task automatic wr(input logic [9:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [9:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_en = 1'b0;
    endtask

    task automatic wbuf(input int off, input logic [7:0] v);
        wr(10'h200 | 10'(off), {24'd0, v});
    endtask

    task automatic fresh(input string req);
        cur_req = req;
        sl_k = 0; sl_bit = 0; cs_falls = 0; sclk_rises = 0; low_seen = '0;
        wr(10'h004, 32'hFF001F1F);
    endtask

    task automatic wait_idle();
        logic [31:0] s;
        for (int i = 0; i < 5000; i++) begin
            rd(10'h004, s);
            if (!s[16]) break;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL R8 watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk(cs_n == 8'hFF, "R1", "cs_n after reset", int'(cs_n), 8'hFF);
        chk(sclk == 1'b0, "R1", "sclk after reset", int'(sclk), 0);
        chk(irq == 1'b0, "R1", "irq after reset", int'(irq), 0);
        rd(10'h004, v);
        chk(v == 32'd0, "R1", "status after reset", int'(v), 0);

        // R2 write-only, R5 chip select 2, R6 done+irq, R7 clear
        wr(10'h008, 32'd1);
        fresh("R2");
        wbuf(0, 8'h40); wbuf(1, 8'h03);
        wbuf(2, 8'h5A); wbuf(3, 8'hC3); wbuf(4, 8'h01);
        exp_q.push_back(8'h5A); exp_q.push_back(8'hC3); exp_q.push_back(8'h01);
        wr(10'h000, 32'h0000_2001);
        wait_idle();
        chk(exp_q.size() == 0, "R2", "bytes left", exp_q.size(), 0);
        chk(cs_falls == 1, "R5", "cs assertions", cs_falls, 1);
        chk(low_seen == 8'h04, "R5", "selected line", int'(low_seen), 8'h04);
        chk(cs_n == 8'hFF, "R5", "cs released", int'(cs_n), 8'hFF);
        rd(10'h004, v);
        chk(v[0] == 1'b1, "R6", "done bit", int'(v[0]), 1);
        chk(irq == 1'b1, "R6", "irq with mask", int'(irq), 1);
        wr(10'h004, 32'hFF001F1F);
        rd(10'h004, v);
        chk(v[0] == 1'b0, "R7", "done after clear", int'(v[0]), 0);
        chk(irq == 1'b0, "R7", "irq after clear", int'(irq), 0);

        // R3 read-write on cs 0
        fresh("R3");
        wbuf(0, 8'h20); wbuf(1, 8'h02); wbuf(2, 8'h11); wbuf(3, 8'h22);
        exp_q.push_back(8'h11); exp_q.push_back(8'h22);
        wr(10'h000, 32'h0000_0001);
        wait_idle();
        chk(exp_q.size() == 0, "R3", "bytes left", exp_q.size(), 0);
        rd(10'h200, v); chk(v[7:0] == 8'hA0, "R3", "rx byte 0", int'(v[7:0]), 8'hA0);
        rd(10'h201, v); chk(v[7:0] == 8'hA1, "R3", "rx byte 1", int'(v[7:0]), 8'hA1);

        // R4 read with two prepended bytes, one cs assertion
        fresh("R4");
        wr(10'h00C, 32'h0200_0000);
        wbuf(0, 8'h60); wbuf(1, 8'h03); wbuf(2, 8'h9F); wbuf(3, 8'h10);
        exp_q.push_back(8'h9F); exp_q.push_back(8'h10);
        exp_q.push_back(8'h00); exp_q.push_back(8'h00); exp_q.push_back(8'h00);
        wr(10'h000, 32'h0000_1001);
        wait_idle();
        chk(exp_q.size() == 0, "R4", "bytes left", exp_q.size(), 0);
        chk(cs_falls == 1, "R4", "single cs assertion", cs_falls, 1);
        rd(10'h200, v); chk(v[7:0] == 8'hA2, "R4", "rx byte 0", int'(v[7:0]), 8'hA2);
        rd(10'h201, v); chk(v[7:0] == 8'hA3, "R4", "rx byte 1", int'(v[7:0]), 8'hA3);
        rd(10'h202, v); chk(v[7:0] == 8'hA4, "R4", "rx byte 2", int'(v[7:0]), 8'hA4);

        // R8 busy flag and ignored start; R6 mask off
        wr(10'h008, 32'd0);
        fresh("R8");
        wbuf(0, 8'h40); wbuf(1, 8'h04);
        for (int i = 0; i < 4; i++) begin
            wbuf(2 + i, 8'(i + 1));
            exp_q.push_back(8'(i + 1));
        end
        wr(10'h000, 32'h0000_3001);
        rd(10'h004, v);
        chk(v[16] == 1'b1, "R8", "busy flag", int'(v[16]), 1);
        wr(10'h000, 32'h0000_5001);
        wait_idle();
        chk(exp_q.size() == 0, "R8", "bytes left", exp_q.size(), 0);
        chk(cs_falls == 1, "R8", "second start ignored", cs_falls, 1);
        chk(low_seen == 8'h08, "R8", "line kept", int'(low_seen), 8'h08);
        rd(10'h004, v);
        chk(v[0] == 1'b1, "R6", "done with mask off", int'(v[0]), 1);
        chk(irq == 1'b0, "R6", "irq masked", int'(irq), 0);
        wr(10'h008, 32'd1);
        @(negedge clk);
        chk(irq == 1'b1, "R6", "irq after unmask", int'(irq), 1);

        // R9 trigger start on cs 1
        fresh("R9");
        wbuf(0, 8'h40); wbuf(1, 8'h01); wbuf(2, 8'h77);
        exp_q.push_back(8'h77);
        wr(10'h000, 32'h0000_1002);
        repeat (40) @(negedge clk);
        chk(cs_falls == 0, "R9", "no start before trigger", cs_falls, 0);
        ext_trig = 1'b1;
        @(negedge clk);
        ext_trig = 1'b0;
        wait_idle();
        chk(exp_q.size() == 0, "R9", "bytes left", exp_q.size(), 0);
        chk(low_seen == 8'h02, "R9", "armed line", int'(low_seen), 8'h02);
        rd(10'h004, v);
        chk(v[0] == 1'b1, "R9", "done", int'(v[0]), 1);

        // R11 flush disarms
        fresh("R11");
        wr(10'h000, 32'h0000_1002);
        wr(10'h000, 32'h0000_0004);
        ext_trig = 1'b1;
        @(negedge clk);
        ext_trig = 1'b0;
        repeat (40) @(negedge clk);
        chk(cs_falls == 0, "R11", "no start after flush", cs_falls, 0);
        rd(10'h004, v);
        chk(v == 32'd0, "R11", "status", int'(v), 0);

        // R10 halt after first byte
        fresh("R10");
        wbuf(0, 8'h40); wbuf(1, 8'h06);
        for (int i = 0; i < 6; i++) wbuf(2 + i, 8'h30 + 8'(i));
        exp_q.push_back(8'h30);
        nbytes = 0;
        wr(10'h000, 32'h0000_6001);
        for (int i = 0; i < 2000 && nbytes == 0; i++) @(negedge clk);
        wr(10'h000, 32'h0000_0003);
        wait_idle();
        repeat (20) @(negedge clk);
        chk(nbytes == 1, "R10", "bytes sent", nbytes, 1);
        chk(cs_n == 8'hFF, "R10", "cs released", int'(cs_n), 8'hFF);
        rd(10'h004, v);
        chk(v[0] == 1'b0, "R10", "no done", int'(v[0]), 0);

        // R12 sleep
        fresh("R12");
        wbuf(0, 8'h00); wbuf(1, 8'h02);
        wr(10'h000, 32'h0000_0001);
        wait_idle();
        chk(cs_falls == 0, "R12", "no chip select", cs_falls, 0);
        chk(sclk_rises == 0, "R12", "no serial clock", sclk_rises, 0);
        rd(10'h004, v);
        chk(v[0] == 1'b1, "R12", "done", int'(v[0]), 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule